// File: doc/BRIEF.md
# Change-of-Flow Trace Recorder

This block sits beside a CPU's retirement stage and receives one event per retired instruction. Each event carries an instruction class, a taken flag, the source and destination addresses, and an interrupt-entry indicator with its vector address. The recorder keeps only the addresses that show the program left its sequential path, and writes them into a circular trace memory.

Some flow changes are logged by their source address and others by their destination address. Each stored word carries a flag that tells the two apart. Taken conditional branches are logged by source. Indexed jumps and calls, returns, and interrupt entries are logged by destination.

Events enter over a valid/ready stream. An event is taken on a clock edge where `ev_valid` and `ev_ready` are both high. While the block is armed, `ev_ready` drops for one cycle after an event that produced two trace words, because the internal two-slot queue is then full. While the block is disarmed, `ev_ready` stays high and accepted events are discarded.

Readout is random access by entry index. It has no back-pressure: a response always appears one cycle after its request.

Top module: `cof_trace_rec`

## Requirements
- R1: An event of class 1 (conditional branch, loop or bit-test branch) with taken=1 stores its source address with the source flag set. With taken=0 it stores nothing.
- R2: An event of class 2 (indexed jump, indexed subroutine call, indexed far call) stores its destination address with the source flag clear.
- R3: An event of class 3 (any return instruction) stores its destination address with the source flag clear.
- R4: An event with the interrupt flag set stores its vector address with the source flag clear. If the background-vector flag is also set, no vector entry is written.
- R5: Classes 0 (sequential) and 4 (direct jumps, direct calls, unconditional branches, branch-to-subroutine, enter-background) store no address of their own.
- R6: When one event yields both a flow-change entry and a vector entry, the flow-change entry is written first and the vector entry second, in consecutive slots, and nothing is lost. `ev_ready` is low for exactly the one cycle after such an event is accepted.
- R7: Each 20-bit entry holds the address in bits [17:0] and the source flag in bit 18 (1 = source, 0 = destination). Bit 19 reads 0.
- R8: The memory holds DEPTH entries and `wr_ptr` wraps from DEPTH-1 to 0. `overflow` sets on the first wrap, and `entry_cnt` saturates at DEPTH.
- R9: A pulse on `arm_req` clears the write pointer, the count and `overflow`, and starts recording. A pulse on `disarm_req` stops recording; it wins if both pulses arrive together. While disarmed, events are accepted and leave the pointer, count and memory contents unchanged.
- R10: A read request returns `rd_rsp_valid` one cycle later. The data is the entry at the requested index if the block was disarmed at the request, and zero if it was armed.
- R11: After reset the block is disarmed, with `wr_ptr`=0, `entry_cnt`=0, `overflow`=0, `ev_ready`=1 and all entries zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_req | input | 1 | Pulse: clear the pointers and start recording |
| disarm_req | input | 1 | Pulse: stop recording |
| ev_valid | input | 1 | Retired-instruction event valid |
| ev_ready | output | 1 | Event can be accepted this cycle |
| ev_cls | input | 3 | Instruction class code (0..4, see R1-R5) |
| ev_taken | input | 1 | Conditional branch was taken |
| ev_src | input | 18 | Address of the retired instruction |
| ev_dst | input | 18 | Destination address of the flow change |
| ev_irq | input | 1 | An interrupt is entered after this instruction |
| ev_bgvec | input | 1 | The vector taken is a background-debug vector |
| ev_vec | input | 18 | Interrupt vector address |
| rd_req_valid | input | 1 | Read request |
| rd_req_idx | input | 6 | Entry index to read |
| rd_rsp_valid | output | 1 | Read response valid |
| rd_rsp_data | output | 20 | Read response entry |
| armed | output | 1 | Recording enabled |
| wr_ptr | output | 6 | Next entry index to be written |
| entry_cnt | output | 7 | Valid entries, saturating at DEPTH |
| overflow | output | 1 | Memory has wrapped since arming |

## Verification
The bench builds the recorder with its defaults: DEPTH=64 and a queue depth of 2. With 64 entries, a few hundred random events push the write pointer through several wraps, so pointer wrap, the overflow flag and count saturation are all reached in one run. It also forces old entries to be overwritten. The two-slot queue is the smallest size that holds a same-cycle flow change and interrupt. That makes the one-cycle stall after a paired event, and the ordering inside the pair, visible on every such event.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
  localparam int ADDR_W = 18;
  localparam int ENT_W  = ADDR_W + 2;

  typedef enum logic [2:0] {
    CLS_SEQ    = 3'd0,
    CLS_COND   = 3'd1,
    CLS_JMPX   = 3'd2,
    CLS_RET    = 3'd3,
    CLS_DIRECT = 3'd4
  } cof_cls_e;

  typedef struct packed {
    logic              rsvd;
    logic              is_src;
    logic [ADDR_W-1:0] addr;
  } trace_ent_t;
endpackage

// File: rtl/cof_classify.sv
module cof_classify
  import cof_trace_pkg::*;
(
  input  cof_cls_e          cls,
  input  logic              taken,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic              irq,
  input  logic              bgvec,
  input  logic [ADDR_W-1:0] vec,
  output logic [1:0]        n_ent,
  output trace_ent_t        ent0,
  output trace_ent_t        ent1
);
  logic       cof_hit, irq_hit;
  trace_ent_t cof_e, irq_e;

  always_comb begin
    cof_hit = 1'b0;
    cof_e   = '0;
    case (cls)
      CLS_COND: begin
        if (taken) begin
          cof_hit      = 1'b1;
          cof_e.is_src = 1'b1;
          cof_e.addr   = src;
        end
      end
      CLS_JMPX, CLS_RET: begin
        cof_hit    = 1'b1;
        cof_e.addr = dst;
      end
      default: cof_hit = 1'b0;
    endcase
    irq_hit    = irq && !bgvec;
    irq_e      = '0;
    irq_e.addr = vec;
    n_ent      = {1'b0, cof_hit} + {1'b0, irq_hit};
    // flow change first, vector second
    ent0       = cof_hit ? cof_e : irq_e;
    ent1       = irq_e;
  end
endmodule

// File: rtl/cof_pair_q.sv
module cof_pair_q
  import cof_trace_pkg::*;
#(
  parameter int QD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic [1:0] push_n,
  input  trace_ent_t push0,
  input  trace_ent_t push1,
  output logic       pop_valid,
  output trace_ent_t pop_ent,
  output logic       room2
);
  localparam int CW = $clog2(QD + 1);

  trace_ent_t     slots  [QD];
  trace_ent_t     nslots [QD];
  logic [CW-1:0]  cnt;
  int             base, ncnt;
  logic           pop;

  always_comb begin
    pop   = (cnt != '0);
    base  = int'(cnt) - (pop ? 1 : 0);
    room2 = (QD - base) >= 2;
    for (int i = 0; i < QD; i++) begin
      nslots[i] = '0;
      if (pop) begin
        if (i + 1 < QD) nslots[i] = slots[i+1];
      end else begin
        nslots[i] = slots[i];
      end
    end
    if (push_n != 2'd0 && base < QD) nslots[base] = push0;
    if (push_n == 2'd2 && base + 1 < QD) nslots[base+1] = push1;
    ncnt = base + int'(push_n);
    if (ncnt > QD) ncnt = QD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < QD; i++) slots[i] <= '0;
    end else if (flush) begin
      cnt <= '0;
    end else begin
      cnt <= CW'(ncnt);
      for (int i = 0; i < QD; i++) slots[i] <= nslots[i];
    end
  end

  assign pop_valid = pop && !flush;
  assign pop_ent   = slots[0];
endmodule

// File: rtl/cof_trace_store.sv
module cof_trace_store
  import cof_trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  trace_ent_t       wr_ent,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_block,
  output logic             rd_valid,
  output logic [ENT_W-1:0] rd_data,
  output logic [IDX_W-1:0] ptr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  trace_ent_t mem [DEPTH];
  logic       at_end;

  assign at_end = (ptr == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && !clear) begin
      mem[ptr] <= wr_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clear) begin
      ptr <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else if (wr_en) begin
      ptr <= at_end ? '0 : ptr + 1'b1;
      if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
      if (at_end) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_block ? '0 : mem[rd_idx];
    end
  end
endmodule

// File: rtl/cof_trace_rec.sv
module cof_trace_rec
  import cof_trace_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int QDEPTH = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_req,
  input  logic             disarm_req,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [2:0]       ev_cls,
  input  logic             ev_taken,
  input  logic [17:0]      ev_src,
  input  logic [17:0]      ev_dst,
  input  logic             ev_irq,
  input  logic             ev_bgvec,
  input  logic [17:0]      ev_vec,
  input  logic             rd_req_valid,
  input  logic [IDX_W-1:0] rd_req_idx,
  output logic             rd_rsp_valid,
  output logic [19:0]      rd_rsp_data,
  output logic             armed,
  output logic [IDX_W-1:0] wr_ptr,
  output logic [CNT_W-1:0] entry_cnt,
  output logic             overflow
);
  logic       clear, room2, pop_valid;
  logic [1:0] n_ent, push_n;
  trace_ent_t ent0, ent1, pop_ent;

  assign clear = arm_req && !disarm_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (disarm_req) armed <= 1'b0;
    else if (arm_req)    armed <= 1'b1;
  end

  cof_classify u_cls (
    .cls   (cof_cls_e'(ev_cls)),
    .taken (ev_taken),
    .src   (ev_src),
    .dst   (ev_dst),
    .irq   (ev_irq),
    .bgvec (ev_bgvec),
    .vec   (ev_vec),
    .n_ent (n_ent),
    .ent0  (ent0),
    .ent1  (ent1)
  );

  assign ev_ready = !armed || room2;
  assign push_n   = (ev_valid && ev_ready && armed && !clear) ? n_ent : 2'd0;

  cof_pair_q #(.QD(QDEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!armed || clear),
    .push_n    (push_n),
    .push0     (ent0),
    .push1     (ent1),
    .pop_valid (pop_valid),
    .pop_ent   (pop_ent),
    .room2     (room2)
  );

  cof_trace_store #(.DEPTH(DEPTH)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .wr_en    (pop_valid),
    .wr_ent   (pop_ent),
    .rd_req   (rd_req_valid),
    .rd_idx   (rd_req_idx),
    .rd_block (armed),
    .rd_valid (rd_rsp_valid),
    .rd_data  (rd_rsp_data),
    .ptr      (wr_ptr),
    .cnt      (entry_cnt),
    .ovf      (overflow)
  );
endmodule

// File: rtl/cof_trace_chk.sv
module cof_trace_chk #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_req,
  input logic             armed,
  input logic             ev_ready,
  input logic             rd_req_valid,
  input logic             rd_rsp_valid,
  input logic [19:0]      rd_rsp_data,
  input logic [IDX_W-1:0] wr_ptr,
  input logic [CNT_W-1:0] entry_cnt,
  input logic             overflow
);
  // R6
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ready |=> ev_ready);

  // R8
  ptr_tracks_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow |-> (entry_cnt < CNT_W'(DEPTH)) && (CNT_W'(wr_ptr) == entry_cnt));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_cnt <= CNT_W'(DEPTH));

  // R9
  ovf_clear_only_by_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !arm_req |=> overflow);

  // R9
  disarmed_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !arm_req |=> $stable(entry_cnt) && $stable(wr_ptr));

  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |=> rd_rsp_valid);

  // R10
  rd_zero_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && armed |=> rd_rsp_data == 20'd0);
endmodule

bind cof_trace_rec cof_trace_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .arm_req      (arm_req),
  .armed        (armed),
  .ev_ready     (ev_ready),
  .rd_req_valid (rd_req_valid),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_data  (rd_rsp_data),
  .wr_ptr       (wr_ptr),
  .entry_cnt    (entry_cnt),
  .overflow     (overflow)
);

// File: tb/tb_cof_trace_rec.sv
module tb_cof_trace_rec;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic arm_req = 0, disarm_req = 0, ev_valid = 0, ev_ready;
  logic [2:0] ev_cls = 0;
  logic ev_taken = 0, ev_irq = 0, ev_bgvec = 0;
  logic [17:0] ev_src = 0, ev_dst = 0, ev_vec = 0;
  logic rd_req_valid = 0, rd_rsp_valid;
  logic [5:0] rd_req_idx = 0;
  logic [19:0] rd_rsp_data;
  logic armed, overflow;
  logic [5:0] wr_ptr;
  logic [6:0] entry_cnt;

  int errors = 0, checks = 0;
  logic [19:0] exp_mem [DEPTH];
  int exp_ptr = 0, exp_cnt = 0;
  bit exp_ovf = 0, m_armed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cof_trace_rec dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(bit s, logic [17:0] a);
    return {1'b0, s, a};
  endfunction

  task automatic model_put(logic [19:0] e);
    exp_mem[exp_ptr] = e;
    if (exp_ptr == DEPTH-1) begin exp_ptr = 0; exp_ovf = 1; end
    else exp_ptr++;
    if (exp_cnt < DEPTH) exp_cnt++;
  endtask

  task automatic model_event(int cls, bit tk, logic [17:0] s, logic [17:0] d,
                             bit irq, bit bg, logic [17:0] v);
    if (!m_armed) return;
    if (cls == 1 && tk) model_put(mk(1, s));
    if (cls == 2 || cls == 3) model_put(mk(0, d));
    if (irq && !bg) model_put(mk(0, v));
  endtask

  task automatic send(int cls, bit tk, logic [17:0] s, logic [17:0] d,
                      bit irq, bit bg, logic [17:0] v);
    @(negedge clk);
    ev_valid = 1; ev_cls = 3'(cls); ev_taken = tk; ev_src = s; ev_dst = d;
    ev_irq = irq; ev_bgvec = bg; ev_vec = v;
    while (!ev_ready) @(negedge clk);
    @(posedge clk);
    model_event(cls, tk, s, d, irq, bg, v);
  endtask

  task automatic idle(int n);
    @(negedge clk); ev_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk); arm_req = 1;
    @(negedge clk); arm_req = 0;
    m_armed = 1; exp_ptr = 0; exp_cnt = 0; exp_ovf = 0;
  endtask

  task automatic do_disarm();
    @(negedge clk); disarm_req = 1;
    @(negedge clk); disarm_req = 0;
    m_armed = 0;
  endtask

  task automatic read_chk(input int idx, input logic [19:0] exp, input string req);
    @(negedge clk); rd_req_valid = 1; rd_req_idx = 6'(idx);
    @(negedge clk); rd_req_valid = 0;
    check({req, " rsp valid"}, 32'(rd_rsp_valid), 1);
    check(req, 32'(rd_rsp_data), 32'(exp));
  endtask

  task automatic status_chk(input string req);
    check({req, " wr_ptr"}, 32'(wr_ptr), 32'(exp_ptr));
    check({req, " entry_cnt"}, 32'(entry_cnt), 32'(exp_cnt));
    check({req, " overflow"}, 32'(overflow), 32'(exp_ovf));
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
    void'($urandom(32'hC0F1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 armed", 32'(armed), 0);
    check("R11 ev_ready", 32'(ev_ready), 1);
    status_chk("R11");
    read_chk(5, 20'd0, "R11 entry zero");

    // directed sequence
    do_arm();
    check("R9 armed after arm", 32'(armed), 1);
    send(2, 0, 18'h01000, 18'h02000, 1, 0, 18'h3FFF2);   // R6 pair: jump dest then vector
    @(negedge clk);
    check("R6 stall after pair", 32'(ev_ready), 0);
    ev_valid = 0;
    @(negedge clk);
    check("R6 ready restored", 32'(ev_ready), 1);
    send(3, 0, 18'h3FFF8, 18'h02000, 0, 0, 0);            // R3 return
    send(1, 1, 18'h02004, 18'h01800, 0, 0, 0);            // R1 taken
    send(1, 0, 18'h02010, 18'h01234, 0, 0, 0);            // R1 not taken
    send(4, 0, 18'h02020, 18'h03000, 0, 0, 0);            // R5 direct
    send(0, 0, 18'h02030, 18'h02031, 0, 0, 0);            // R5 sequential
    send(0, 0, 18'h02040, 18'h02041, 1, 1, 18'h3FFF6);    // R4 background vector
    send(2, 0, 18'h02050, 18'h2ABCD, 1, 1, 18'h3FFF6);    // R2 + background vector
    send(1, 1, 18'h15555, 18'h00000, 1, 0, 18'h3FFE0);    // R6 source then vector
    idle(3);
    status_chk("R1-R6 count");
    do_disarm();
    read_chk(0, mk(0, 18'h02000), "R2 jump dest first");
    read_chk(1, mk(0, 18'h3FFF2), "R6 vector second");
    read_chk(2, mk(0, 18'h02000), "R3 return dest");
    read_chk(3, mk(1, 18'h02004), "R1 R7 source flag");
    read_chk(4, mk(0, 18'h2ABCD), "R2 R4 R5 no extra entries");
    read_chk(5, mk(1, 18'h15555), "R6 source before vector");
    read_chk(6, mk(0, 18'h3FFE0), "R4 vector");
    read_chk(7, 20'd0, "R5 nothing beyond");

    // R9 disarmed events ignored
    send(2, 0, 18'h0AAAA, 18'h0BBBB, 1, 0, 18'h0CCCC);
    check("R9 ready while disarmed", 32'(ev_ready), 1);
    idle(3);
    status_chk("R9 disarmed unchanged");
    read_chk(7, 20'd0, "R9 memory untouched");

    // R10 reads while armed return zero
    do_arm();
    status_chk("R9 arm clears");
    read_chk(0, 20'd0, "R10 zero while armed");

    // random phase, R8 wrap
    for (int n = 0; n < 300; n++) begin
      int cls, gap;
      cls = int'($urandom % 5);
      gap = int'($urandom % 4);
      if (gap == 0) idle(1);
      send(cls, 1'($urandom), 18'($urandom), 18'($urandom),
           ($urandom % 4) == 0, ($urandom % 8) == 0, 18'($urandom));
      if (n == 150 && exp_cnt == DEPTH) check("R8 saturate", 32'(entry_cnt) <= 64, 1);
    end
    idle(3);
    status_chk("R8 after random");
    check("R8 overflow reached", 32'(exp_ovf), 1);
    do_disarm();
    for (int i = 0; i < DEPTH; i++) read_chk(i, exp_mem[i], "R7 R8 random entry");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule